// File: doc/BRIEF.md
# Strided Block Transfer Engine over a Bit-Serial Neighbour Link

This block moves data between the local memory of one node and the memory of an adjacent node over one single-bit serial wire per direction. A processor writes a base address, a stride, a block count and a block length into a small register file. It then starts the engine in either send or receive mode and polls a done flag to learn when the transfer has finished. In send mode the engine gathers words from memory in strided blocks and shifts each one out as a framed serial word. In receive mode it deserializes arriving frames and scatters them into memory using the same address pattern.

The two ends of a link are programmed on their own, in any order and with any delay between them. A ready/acknowledge pair travelling against the data wire makes an armed sender wait until the receiver is armed and has room for a word. The sender then waits for each word to be acknowledged before it launches the next one, so a word is never lost or overwritten. One engine instance serves one link direction. A bidirectional neighbour link uses two instances and two data wires.

Top module: `strided_link_engine`

## Requirements
- R1: Register writes with `cfg_we` high select a register by `cfg_sel`: 0 base address, 1 stride, 2 block count, 3 block length, 4 control. A control write with bit 0 set starts a transfer, and bit 1 picks receive (1) or send (0). An accepted start in send or receive mode raises `busy_o` in the next cycle.
- R2: Word j (0-based) of block i (0-based) uses address base + i*stride + j. Blocks are handled in ascending i and words within a block in ascending j, on both the memory read side and the memory write side.
- R3: The serial line idles low. A frame is one start bit of value 1, then 32 data bits least significant first, then one parity bit equal to the XOR of the 32 data bits, with one bit per clock cycle.
- R4: A sender launches a word only after it has seen `link_rdy_i` high, and it launches no further word until it has seen `link_ack_i` for the previous one. While the peer is not ready the serial line stays low and the engine stays busy.
- R5: A receiver drives `link_rdy_o` high only while it is armed and holds no undelivered word. It writes each received word to memory and pulses `link_ack_o` for exactly one cycle per word.
- R6: For any arming order and any delay between the two ends, the receiving memory afterwards holds every source word at its strided destination address, and every other address is left unchanged.
- R7: `done_o` rises in the cycle after the last word is written (receive) or acknowledged (send), with `busy_o` low. `done_o` is cleared by the next accepted start.
- R8: A start with a block count or block length of zero sets `done_o` in the cycle after the start write. `busy_o` is not raised, and there is no memory request and no serial activity.
- R9: A start written while `busy_o` is high is ignored. The running transfer continues unchanged and no new transfer begins after it.
- R10: A received parity mismatch sets `par_err_o`, which stays high until the next accepted start. The word is still stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select (0 base, 1 stride, 2 blocks, 3 length, 4 control) |
| cfg_wdata | input | 32 | Register write data |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | Last transfer complete |
| par_err_o | output | 1 | Sticky receive parity error |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Memory write (1) or read (0) |
| mem_addr_o | output | AW | Memory word address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_rdata_i | input | 32 | Memory read data, valid the cycle after a read request |
| link_tx_o | output | 1 | Outgoing serial data |
| link_rx_i | input | 1 | Incoming serial data |
| link_rdy_o | output | 1 | This receiver is armed and can take a word |
| link_rdy_i | input | 1 | Peer receiver is armed and can take a word |
| link_ack_o | output | 1 | Per-word acknowledge to the peer sender |
| link_ack_i | input | 1 | Per-word acknowledge from the peer receiver |

## Verification
The two functions that can land in the same cycle are a processor start write and the engine's own step through the address sequence. The sharpest case is a control write that arrives while a send is waiting for its final acknowledge, or right when the last word is written. The bench provokes this by writing a receive-mode start into a busy sender partway through a strided send. It then judges the outcome at the ports: the transfer must finish intact, `busy_o` must stay low afterwards and no memory write may appear. A second overlap is a transfer armed from both ends with random relative delays, where a ready level and a returning acknowledge may meet in the cycle that the sender steps its address. The full destination image is compared word by word against a strided map that the bench builds itself.

// File: rtl/strided_link_pkg.sv
package strided_link_pkg;
  localparam int WORD_W     = 32;
  localparam int FRAME_BITS = WORD_W + 2;
  localparam int FCNT_W     = $clog2(FRAME_BITS + 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_WAIT_RDY, ST_FETCH, ST_LOAD, ST_WAIT_ACK, ST_RECV, ST_WRITE
  } eng_state_t;

  localparam logic [2:0] SEL_BASE   = 3'd0;
  localparam logic [2:0] SEL_STRIDE = 3'd1;
  localparam logic [2:0] SEL_BLOCKS = 3'd2;
  localparam logic [2:0] SEL_LEN    = 3'd3;
  localparam logic [2:0] SEL_CTRL   = 3'd4;

  function automatic logic word_parity(input logic [WORD_W-1:0] w);
    return ^w;
  endfunction

  // Frame as shifted out from bit 0: start, data LSB first, parity.
  function automatic logic [FRAME_BITS-1:0] build_frame(input logic [WORD_W-1:0] w);
    return {word_parity(w), w, 1'b1};
  endfunction

  function automatic logic [31:0] strided_addr(input logic [31:0] base, input logic [31:0] stride,
                                               input logic [31:0] blk, input logic [31:0] wrd);
    return base + blk * stride + wrd;
  endfunction
endpackage

// File: rtl/sl_addr_gen.sv
module sl_addr_gen #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] stride_i,
  input  logic [CW-1:0] blocks_i,
  input  logic [CW-1:0] len_i,
  input  logic          step,
  output logic [AW-1:0] addr_o,
  output logic          last_o
);
  logic [AW-1:0] blk_base_q, stride_q;
  logic [CW-1:0] wrd_q, blk_q, len_q, blocks_q;
  logic          blk_end;

  assign blk_end = (wrd_q == len_q - CW'(1));
  assign last_o  = blk_end && (blk_q == blocks_q - CW'(1));
  assign addr_o  = blk_base_q + AW'(wrd_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      blk_base_q <= '0;
      stride_q   <= '0;
      wrd_q      <= '0;
      blk_q      <= '0;
      len_q      <= '0;
      blocks_q   <= '0;
    end else if (load) begin
      blk_base_q <= base_i;
      stride_q   <= stride_i;
      wrd_q      <= '0;
      blk_q      <= '0;
      len_q      <= len_i;
      blocks_q   <= blocks_i;
    end else if (step) begin
      if (blk_end) begin
        wrd_q      <= '0;
        blk_q      <= blk_q + CW'(1);
        blk_base_q <= blk_base_q + stride_q;
      end else begin
        wrd_q <= wrd_q + CW'(1);
      end
    end
  end

  // R2
  addr_contig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step && !load && !blk_end |=> addr_o == $past(addr_o) + AW'(1));
  // R2
  addr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> addr_o == $past(base_i));
endmodule

// File: rtl/sl_serializer.sv
module sl_serializer
  import strided_link_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] word_i,
  output logic              tx_o,
  output logic              busy_o
);
  logic [FRAME_BITS-1:0] sh_q;
  logic [FCNT_W-1:0]     cnt_q;
  logic                  tx_q;

  assign tx_o   = tx_q;
  assign busy_o = (cnt_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
      tx_q  <= 1'b0;
    end else if (cnt_q != '0) begin
      tx_q  <= sh_q[0];
      sh_q  <= sh_q >> 1;
      cnt_q <= cnt_q - FCNT_W'(1);
    end else begin
      tx_q <= 1'b0;
      if (load) begin
        sh_q  <= build_frame(word_i);
        cnt_q <= FCNT_W'(FRAME_BITS);
      end
    end
  end

  // R3
  tx_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |=> !tx_o);
  // R3
  tx_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load && !busy_o |=> ##1 tx_o);
endmodule

// File: rtl/sl_deserializer.sv
module sl_deserializer
  import strided_link_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              rx_i,
  output logic              busy_o,
  output logic              valid_o,
  output logic [WORD_W-1:0] word_o,
  output logic              perr_o
);
  logic [WORD_W-1:0] sh_q;
  logic [FCNT_W-1:0] cnt_q;
  logic              valid_q, perr_q;

  assign busy_o  = (cnt_q != '0);
  assign valid_o = valid_q;
  assign word_o  = sh_q;
  assign perr_o  = perr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q    <= '0;
      cnt_q   <= '0;
      valid_q <= 1'b0;
      perr_q  <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (cnt_q == '0) begin
        if (en && rx_i) cnt_q <= FCNT_W'(FRAME_BITS - 1);
      end else if (cnt_q == FCNT_W'(1)) begin
        valid_q <= 1'b1;
        perr_q  <= rx_i ^ word_parity(sh_q);
        cnt_q   <= '0;
      end else begin
        sh_q  <= {rx_i, sh_q[WORD_W-1:1]};
        cnt_q <= cnt_q - FCNT_W'(1);
      end
    end
  end

  // R3
  one_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);
endmodule

// File: rtl/strided_link_engine.sv
module strided_link_engine
  import strided_link_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_sel,
  input  logic [31:0]   cfg_wdata,
  output logic          busy_o,
  output logic          done_o,
  output logic          par_err_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [31:0]   mem_wdata_o,
  input  logic [31:0]   mem_rdata_i,
  output logic          link_tx_o,
  input  logic          link_rx_i,
  output logic          link_rdy_o,
  input  logic          link_rdy_i,
  output logic          link_ack_o,
  input  logic          link_ack_i
);
  eng_state_t st_q;
  logic [AW-1:0] base_q, stride_q;
  logic [CW-1:0] blocks_q, len_q;
  logic          rx_mode_q, done_q, perr_q, ack_got_q;
  logic [WORD_W-1:0] wbuf_q;

  // Named internal events
  logic start_wr, start_acc, cfg_empty, ack_seen;
  logic ag_step, ag_last, ser_load, ser_busy;
  logic des_busy, des_valid, des_perr;
  logic [AW-1:0]     ag_addr;
  logic [WORD_W-1:0] des_word;

  assign start_wr  = cfg_we && (cfg_sel == SEL_CTRL) && cfg_wdata[0];
  assign start_acc = start_wr && (st_q == ST_IDLE);
  assign cfg_empty = (blocks_q == '0) || (len_q == '0);
  assign ack_seen  = ack_got_q || link_ack_i;
  assign ser_load  = (st_q == ST_LOAD);
  assign ag_step   = ((st_q == ST_WAIT_ACK) && ack_seen && !ser_busy) || (st_q == ST_WRITE);

  assign busy_o      = (st_q != ST_IDLE);
  assign done_o      = done_q;
  assign par_err_o   = perr_q;
  assign mem_req_o   = (st_q == ST_FETCH) || (st_q == ST_WRITE);
  assign mem_we_o    = (st_q == ST_WRITE);
  assign mem_addr_o  = ag_addr;
  assign mem_wdata_o = wbuf_q;
  assign link_rdy_o  = (st_q == ST_RECV) && !des_busy && !des_valid;
  assign link_ack_o  = (st_q == ST_WRITE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q   <= '0;
      stride_q <= '0;
      blocks_q <= '0;
      len_q    <= '0;
    end else if (cfg_we) begin
      case (cfg_sel)
        SEL_BASE:   base_q   <= cfg_wdata[AW-1:0];
        SEL_STRIDE: stride_q <= cfg_wdata[AW-1:0];
        SEL_BLOCKS: blocks_q <= cfg_wdata[CW-1:0];
        SEL_LEN:    len_q    <= cfg_wdata[CW-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      rx_mode_q <= 1'b0;
      done_q    <= 1'b0;
      perr_q    <= 1'b0;
      ack_got_q <= 1'b0;
      wbuf_q    <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (start_acc) begin
          rx_mode_q <= cfg_wdata[1];
          perr_q    <= 1'b0;
          done_q    <= cfg_empty;
          if (!cfg_empty) st_q <= cfg_wdata[1] ? ST_RECV : ST_WAIT_RDY;
        end
        ST_WAIT_RDY: if (link_rdy_i) st_q <= ST_FETCH;
        ST_FETCH:    st_q <= ST_LOAD;
        ST_LOAD: begin
          ack_got_q <= 1'b0;
          st_q      <= ST_WAIT_ACK;
        end
        ST_WAIT_ACK: begin
          if (link_ack_i) ack_got_q <= 1'b1;
          if (ack_seen && !ser_busy) begin
            ack_got_q <= 1'b0;
            if (ag_last) begin
              done_q <= 1'b1;
              st_q   <= ST_IDLE;
            end else begin
              st_q <= ST_WAIT_RDY;
            end
          end
        end
        ST_RECV: if (des_valid) begin
          wbuf_q <= des_word;
          if (des_perr) perr_q <= 1'b1;
          st_q <= ST_WRITE;
        end
        ST_WRITE: begin
          if (ag_last) begin
            done_q <= 1'b1;
            st_q   <= ST_IDLE;
          end else begin
            st_q <= ST_RECV;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  sl_addr_gen #(.AW(AW), .CW(CW)) addr_i (
    .clk(clk), .rst_n(rst_n), .load(start_acc),
    .base_i(base_q), .stride_i(stride_q), .blocks_i(blocks_q), .len_i(len_q),
    .step(ag_step), .addr_o(ag_addr), .last_o(ag_last)
  );

  sl_serializer ser_i (
    .clk(clk), .rst_n(rst_n), .load(ser_load), .word_i(mem_rdata_i),
    .tx_o(link_tx_o), .busy_o(ser_busy)
  );

  sl_deserializer des_i (
    .clk(clk), .rst_n(rst_n), .en(st_q == ST_RECV), .rx_i(link_rx_i),
    .busy_o(des_busy), .valid_o(des_valid), .word_o(des_word), .perr_o(des_perr)
  );

  // R1
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_acc && !cfg_empty |=> busy_o && !done_o);
  // R4
  launch_after_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ser_load |-> $past(link_rdy_i, 2));
  // R4
  no_fetch_before_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAIT_ACK) && !ack_seen |=> !mem_req_o);
  // R5
  rdy_only_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    link_rdy_o |-> rx_mode_q && busy_o);
  // R5
  write_only_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o && mem_we_o |-> rx_mode_q);
  // R7
  done_busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && busy_o));
  // R8
  empty_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_acc && cfg_empty |=> done_o && !busy_o && !mem_req_o);
  // R9
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_wr && busy_o |=> $stable(rx_mode_q));
  // R10
  perr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    par_err_o && !start_acc |=> par_err_o);
endmodule

// File: tb/strided_link_engine_tb_top.sv
module sl_tb_mem #(
  parameter int DEPTH = 1024
) (
  input  logic        clk,
  input  logic        req,
  input  logic        we,
  input  logic [15:0] addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata
);
  logic [31:0] arr [0:DEPTH-1];
  always @(posedge clk) begin
    if (req && we) arr[addr[9:0]] <= wdata;
    if (req && !we) rdata <= arr[addr[9:0]];
  end
endmodule

module strided_link_engine_tb_top;
  localparam int MEMN = 1024;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;
  int cyc = 0;

  // Instance A (dut_i), B (peer_i), C (rxchk_i, bench-driven line)
  logic a_we = 0, b_we = 0, c_we = 0;
  logic [2:0] a_sel = 0, b_sel = 0, c_sel = 0;
  logic [31:0] a_wd = 0, b_wd = 0, c_wd = 0;
  logic a_busy, a_done, a_err, a_req, a_mwe, a_tx, a_rdy, a_ack;
  logic b_busy, b_done, b_err, b_req, b_mwe, b_tx, b_rdy, b_ack;
  logic c_busy, c_done, c_err, c_req, c_mwe, c_tx, c_rdy, c_ack;
  logic c_rx = 0;
  logic [15:0] a_addr, b_addr, c_addr;
  logic [31:0] a_mwd, b_mwd, c_mwd, a_rd, b_rd, c_rd;

  strided_link_engine dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(a_we), .cfg_sel(a_sel), .cfg_wdata(a_wd),
    .busy_o(a_busy), .done_o(a_done), .par_err_o(a_err),
    .mem_req_o(a_req), .mem_we_o(a_mwe), .mem_addr_o(a_addr), .mem_wdata_o(a_mwd), .mem_rdata_i(a_rd),
    .link_tx_o(a_tx), .link_rx_i(b_tx), .link_rdy_o(a_rdy), .link_rdy_i(b_rdy),
    .link_ack_o(a_ack), .link_ack_i(b_ack));

  strided_link_engine peer_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(b_we), .cfg_sel(b_sel), .cfg_wdata(b_wd),
    .busy_o(b_busy), .done_o(b_done), .par_err_o(b_err),
    .mem_req_o(b_req), .mem_we_o(b_mwe), .mem_addr_o(b_addr), .mem_wdata_o(b_mwd), .mem_rdata_i(b_rd),
    .link_tx_o(b_tx), .link_rx_i(a_tx), .link_rdy_o(b_rdy), .link_rdy_i(a_rdy),
    .link_ack_o(b_ack), .link_ack_i(a_ack));

  strided_link_engine rxchk_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(c_we), .cfg_sel(c_sel), .cfg_wdata(c_wd),
    .busy_o(c_busy), .done_o(c_done), .par_err_o(c_err),
    .mem_req_o(c_req), .mem_we_o(c_mwe), .mem_addr_o(c_addr), .mem_wdata_o(c_mwd), .mem_rdata_i(c_rd),
    .link_tx_o(c_tx), .link_rx_i(c_rx), .link_rdy_o(c_rdy), .link_rdy_i(1'b0),
    .link_ack_o(c_ack), .link_ack_i(1'b0));

  sl_tb_mem mem_a (.clk(clk), .req(a_req), .we(a_mwe), .addr(a_addr), .wdata(a_mwd), .rdata(a_rd));
  sl_tb_mem mem_b (.clk(clk), .req(b_req), .we(b_mwe), .addr(b_addr), .wdata(b_mwd), .rdata(b_rd));
  sl_tb_mem mem_c (.clk(clk), .req(c_req), .we(c_mwe), .addr(c_addr), .wdata(c_mwd), .rdata(c_rd));

  // Port monitors sampled away from the active edge
  int a_tx_cnt = 0, a_req_cnt = 0, a_wr_cnt = 0, b_ack_cnt = 0, c_ack_cnt = 0;
  int b_last_wr = -1, b_done_rise = -1;
  logic b_done_prev = 0;
  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (a_tx) a_tx_cnt <= a_tx_cnt + 1;
    if (a_req) a_req_cnt <= a_req_cnt + 1;
    if (a_req && a_mwe) a_wr_cnt <= a_wr_cnt + 1;
    if (b_ack) b_ack_cnt <= b_ack_cnt + 1;
    if (c_ack) c_ack_cnt <= c_ack_cnt + 1;
    if (b_req && b_mwe) b_last_wr <= cyc;
    if (b_done && !b_done_prev) b_done_rise <= cyc;
    b_done_prev <= b_done;
  end

  logic [31:0] expv [0:MEMN-1];

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic write_reg(input int which, input logic [2:0] sel, input logic [31:0] data);
    @(negedge clk);
    case (which)
      0: begin a_we = 1; a_sel = sel; a_wd = data; end
      1: begin b_we = 1; b_sel = sel; b_wd = data; end
      default: begin c_we = 1; c_sel = sel; c_wd = data; end
    endcase
    @(negedge clk);
    case (which)
      0: a_we = 0;
      1: b_we = 0;
      default: c_we = 0;
    endcase
  endtask

  task automatic prog(input int which, input int base, input int stride, input int blocks,
                      input int len, input bit rx);
    write_reg(which, 3'd0, base);
    write_reg(which, 3'd1, stride);
    write_reg(which, 3'd2, blocks);
    write_reg(which, 3'd3, len);
    write_reg(which, 3'd4, {30'd0, rx, 1'b1});
  endtask

  task automatic wait_done(input int which, output bit ok);
    ok = 0;
    for (int k = 0; k < 20000; k++) begin
      @(negedge clk);
      if ((which == 0 && a_done) || (which == 1 && b_done) || (which == 2 && c_done)) begin
        ok = 1;
        break;
      end
    end
  endtask

  task automatic fill_mems();
    for (int k = 0; k < MEMN; k++) begin
      mem_a.arr[k] = $urandom;
      mem_b.arr[k] = 32'hBAD0_0000 | k;
    end
  endtask

  // Bench map: destination word = source word at the matching strided position
  task automatic check_image(input string req, input int tb, input int ts, input int rb,
                             input int rs, input int nb, input int nl);
    int bad = 0;
    int first = -1;
    for (int k = 0; k < MEMN; k++) expv[k] = 32'hBAD0_0000 | k;
    for (int i = 0; i < nb; i++)
      for (int j = 0; j < nl; j++)
        expv[rb + i * rs + j] = mem_a.arr[tb + i * ts + j];
    for (int k = 0; k < MEMN; k++)
      if (mem_b.arr[k] !== expv[k]) begin
        bad++;
        if (first < 0) first = k;
      end
    check(bad == 0, req, "destination image", (first < 0) ? 0 : mem_b.arr[first],
          (first < 0) ? 0 : expv[first]);
  endtask

  task automatic send_frame(input logic [31:0] w, input bit flip, output bit acked);
    int lim = 0;
    acked = 0;
    while (!c_rdy && lim < 1000) begin @(negedge clk); lim++; end
    for (int b = 0; b < 34; b++) begin
      if (b == 0) c_rx = 1'b1;
      else if (b <= 32) c_rx = w[b-1];
      else c_rx = (^w) ^ flip;
      @(negedge clk);
    end
    c_rx = 1'b0;
    for (int k = 0; k < 20; k++) begin
      if (c_ack) acked = 1;
      @(negedge clk);
    end
  endtask

  initial begin
    bit ok, ok2, acked;
    int da, db, nb, nl, ts, rs, tbs, rbs, n0, n1;
    void'($urandom(32'd4242));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // Reset state
    check(!a_busy && !a_done && !a_err && !a_tx && !a_rdy && !a_ack && !a_req, "R1",
          "idle after reset", {a_busy, a_done, a_err, a_tx, a_rdy, a_ack, a_req}, 0);

    // Directed: sender armed first, peer absent (R4), then receiver armed
    fill_mems();
    a_tx_cnt = 0;
    prog(0, 10, 5, 2, 3, 0);
    check(a_busy == 1, "R1", "busy after start", a_busy, 1);
    repeat (200) @(negedge clk);
    check(a_tx_cnt == 0 && a_busy, "R4", "stalled sender line quiet", a_tx_cnt, 0);
    b_ack_cnt = 0;
    prog(1, 300, 4, 2, 3, 1);
    wait_done(0, ok); wait_done(1, ok2);
    check(ok && ok2, "R6", "both ends done", {ok, ok2}, 3);
    check_image("R2", 10, 5, 300, 4, 2, 3);
    check(b_ack_cnt == 6, "R5", "one ack per word", b_ack_cnt, 6);
    check(b_done_rise == b_last_wr + 1, "R7", "done cycle after last write",
          b_done_rise, b_last_wr + 1);
    check(!a_busy && !b_busy, "R7", "busy low with done", {a_busy, b_busy}, 0);

    // Directed: receiver armed first (R5), busy start injected into sender (R9)
    fill_mems();
    prog(1, 500, 9, 3, 4, 1);
    check(b_done == 0, "R7", "done cleared by start", b_done, 0);
    repeat (150) @(negedge clk);
    check(b_rdy == 1, "R5", "armed receiver ready", b_rdy, 1);
    a_wr_cnt = 0;
    prog(0, 40, 6, 3, 4, 0);
    repeat (170) @(negedge clk);
    write_reg(0, 3'd4, 32'h3);
    wait_done(0, ok); wait_done(1, ok2);
    n0 = a_wr_cnt;
    repeat (200) @(negedge clk);
    check(ok && ok2 && !a_busy && a_done && a_wr_cnt == 0 && n0 == 0, "R9",
          "start while busy ignored", a_wr_cnt, 0);
    check_image("R9", 40, 6, 500, 9, 3, 4);

    // Zero block count and zero length (R8)
    for (int z = 0; z < 2; z++) begin
      a_tx_cnt = 0; a_req_cnt = 0;
      prog(0, 3, 1, (z == 0) ? 0 : 2, (z == 0) ? 4 : 0, 0);
      check(a_done == 1 && a_busy == 0, "R8", "zero transfer done at once", {a_done, a_busy}, 2);
      repeat (20) @(negedge clk);
      check(a_tx_cnt == 0 && a_req_cnt == 0 && !a_busy, "R8", "no link or memory activity",
            a_tx_cnt + a_req_cnt, 0);
    end

    // Random arming order and shapes (R6, R2)
    for (int r = 0; r < 8; r++) begin
      fill_mems();
      nb = 1 + $urandom % 4; nl = 1 + $urandom % 6;
      ts = nl + $urandom % 8; rs = nl + $urandom % 8;
      tbs = $urandom % 100; rbs = 200 + $urandom % 100;
      da = $urandom % 80; db = $urandom % 80;
      fork
        begin repeat (da) @(negedge clk); prog(0, tbs, ts, nb, nl, 0); end
        begin repeat (db) @(negedge clk); prog(1, rbs, rs, nb, nl, 1); end
      join
      wait_done(0, ok); wait_done(1, ok2);
      check(ok && ok2, "R6", "random run completes", {ok, ok2}, 3);
      check_image("R6", tbs, ts, rbs, rs, nb, nl);
    end

    // Parity error on a bench-driven line (R3, R10)
    for (int k = 0; k < 4; k++) mem_c.arr[k] = 0;
    prog(2, 0, 1, 1, 2, 1);
    c_ack_cnt = 0;
    send_frame(32'h1234_5678, 0, acked);
    check(acked && !c_err && mem_c.arr[0] == 32'h1234_5678, "R3", "good frame stored",
          mem_c.arr[0], 32'h1234_5678);
    send_frame(32'hCAFE_F00D, 1, acked);
    wait_done(2, ok);
    check(ok && c_err == 1, "R10", "parity mismatch flagged", c_err, 1);
    check(mem_c.arr[1] == 32'hCAFE_F00D, "R10", "bad word still stored", mem_c.arr[1], 32'hCAFE_F00D);
    check(c_ack_cnt == 2, "R5", "ack per received word", c_ack_cnt, 2);
    repeat (10) @(negedge clk);
    check(c_err == 1, "R10", "error flag sticky", c_err, 1);
    prog(2, 0, 1, 0, 0, 1);
    check(c_err == 0, "R10", "error cleared by start", c_err, 0);

    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
      $display("  test done: total=%0d bad=%0d", checks, fails);
      $finish;
    end
  end
endmodule